// File: doc/BRIEF.md
# Cartridge-Disk Controller Command Register Front-End

This block sits between a processor bus and an external emulation server and models the command registers of a cartridge-disk controller. The processor writes a control/status word that carries a start bit and a three-bit function code, plus a disk-address word whose top three bits select one of eight drives. Most functions are handed to the server through an attention request. The server acknowledges the request and later reports completion, and the controller is busy from the start of the function until that completion.

Two functions never reach the server: control reset and write-lock. Write-lock sets the addressed drive's protect flag on the same clock edge as the register write. A control reset that follows on the very next bus cycle therefore cannot undo it. Write and write-check commands aimed at a protected drive are refused locally: the block sets an error bit and raises no attention. The per-drive protect flags can be read back through a drive-status word.

Top module: `dskctl_regs`

## Requirements
- R1: After reset the control/status word reads 0x0080 (ready set, function 0, no error), the disk-address word reads 0, every drive reads as unprotected, and attention is low.
- R2: In the control/status word, bit 0 is the start bit and always reads 0, bits 3:1 hold the function code, bit 7 is ready and bit 13 is the write-lock error. A write with bit 0 clear stores the function code and starts nothing.
- R3: The function codes are 0 control reset, 1 write, 2 read, 3 write check, 4 seek, 5 read check, 6 drive reset and 7 write lock. A started function 1 to 6 that is not refused clears ready and raises attention on the clock edge of the write. On that same edge the server function output takes the code and the server drive output takes disk-address bits 15:13.
- R4: Attention stays high until the cycle in which acknowledge or done is seen. It is low from the following edge.
- R5: A done pulse from the server while busy sets ready again.
- R6: While busy, writes to the control/status and disk-address words are ignored, including a start bit.
- R7: A started write-lock sets the protect flag of the drive in disk-address bits 15:13 on the edge of the write. It raises no attention and leaves ready set.
- R8: A write-lock followed on the next bus cycle by a control reset leaves that drive protected.
- R9: A started control reset clears the function code, the error bit and the disk-address word. It raises no attention and keeps every protect flag.
- R10: A started write (1) or write check (3) to a protected drive sets the error bit, raises no attention and keeps ready set. A read (2) to a protected drive is forwarded normally.
- R11: Register select 0 is control/status, 1 is disk address, 2 is drive status and 3 reads 0. Drive status carries the selected drive number in bits 15:13 and its protect flag in bit 5, and all other bits are 0.
- R12: A start that is forwarded, or that performs a write-lock, clears the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_sel | input | 2 | Register selected for the write |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Register selected for read-back |
| rd_data | output | 16 | Read-back data, combinational from state |
| attn_req | output | 1 | Attention request to the server |
| attn_ack | input | 1 | Server acknowledge of the attention |
| srv_done | input | 1 | Server reports the function complete |
| srv_func | output | 3 | Function code handed to the server |
| srv_drive | output | 3 | Drive number handed to the server |

## Verification
The assertions assume that the server raises done only after it has seen attention, and that acknowledge and done are single-cycle pulses while the controller is busy. The attention-hold property is therefore written to excuse the cycle that carries done. The bench applies acknowledge and done only after a forwarded start, and it drives at most one bus write per clock. It also sends a write-lock directly followed by a control reset, and it writes the registers while the controller is busy, so that the refused and ignored cases are seen at the ports.

// File: rtl/dskctl_pkg.sv
package dskctl_pkg;
  typedef enum logic [2:0] {
    FN_CRESET = 3'd0,
    FN_WRITE  = 3'd1,
    FN_READ   = 3'd2,
    FN_WCHK   = 3'd3,
    FN_SEEK   = 3'd4,
    FN_RCHK   = 3'd5,
    FN_DRESET = 3'd6,
    FN_WLOCK  = 3'd7
  } func_e;

  localparam logic [1:0] SEL_CSR  = 2'd0;
  localparam logic [1:0] SEL_DA   = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;

  localparam int CSR_RDY_BIT = 7;
  localparam int CSR_WLE_BIT = 13;
  localparam int STAT_WP_BIT = 5;
endpackage

// File: rtl/dskctl_decode.sv
module dskctl_decode
  import dskctl_pkg::*;
(
  input  logic       csr_wr,
  input  logic [3:0] cmd_bits,
  input  logic       ready,
  input  logic       drv_prot,
  output logic       func_ld,
  output logic       go_creset,
  output logic       go_wlock,
  output logic       go_refuse,
  output logic       go_fwd
);
  func_e fn;
  logic  go_ok;

  always_comb begin
    fn        = func_e'(cmd_bits[3:1]);
    func_ld   = csr_wr && ready;
    go_ok     = func_ld && cmd_bits[0];
    go_creset = go_ok && (fn == FN_CRESET);
    go_wlock  = go_ok && (fn == FN_WLOCK);
    go_refuse = go_ok && drv_prot && ((fn == FN_WRITE) || (fn == FN_WCHK));
    go_fwd    = go_ok && !go_creset && !go_wlock && !go_refuse;
  end
endmodule

// File: rtl/dskctl_protect.sv
module dskctl_protect #(
  parameter int DRV_W = 3,
  localparam int NDRV = 1 << DRV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [DRV_W-1:0] set_drv,
  output logic [NDRV-1:0]  flags
);
  logic [NDRV-1:0] flags_n;

  for (genvar i = 0; i < NDRV; i++) begin : g_drv
    always_comb flags_n[i] = flags[i] | (set_en && (set_drv == i[DRV_W-1:0]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  flags[i] <= 1'b0;
      else         flags[i] <= flags_n[i];
    end
  end

  // protect flags are sticky: nothing but reset clears them
  assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flags) & ~flags) == '0));
endmodule

// File: rtl/dskctl_attn.sv
module dskctl_attn (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack,
  input  logic done,
  output logic attn
);
  logic attn_n;

  always_comb begin
    attn_n = attn;
    if (ack || done) attn_n = 1'b0;
    if (start)       attn_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) attn <= 1'b0;
    else        attn <= attn_n;
  end

  assert_attn_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    attn && !ack && !done |=> attn);
  assert_attn_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    attn && (ack || done) && !start |=> !attn);
endmodule

// File: rtl/dskctl_regs.sv
module dskctl_regs
  import dskctl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DRV_W  = 3,
  localparam int FUNC_W = 3,
  localparam int NDRV   = 1 << DRV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              attn_req,
  input  logic              attn_ack,
  input  logic              srv_done,
  output logic [FUNC_W-1:0] srv_func,
  output logic [DRV_W-1:0]  srv_drive
);
  logic [FUNC_W-1:0] func_q, func_n;
  logic              wle_q, wle_n;
  logic              ready_q, ready_n;
  logic [DATA_W-1:0] da_q, da_n;
  logic [FUNC_W-1:0] sfunc_n;
  logic [DRV_W-1:0]  sdrv_n;
  logic [DRV_W-1:0]  da_drv;
  logic [NDRV-1:0]   prot;
  logic              csr_wr, da_wr;
  logic              func_ld, go_creset, go_wlock, go_refuse, go_fwd;

  assign da_drv = da_q[DATA_W-1 -: DRV_W];
  assign csr_wr = wr_en && (wr_sel == SEL_CSR);
  assign da_wr  = wr_en && (wr_sel == SEL_DA);

  dskctl_decode i_decode (
    .csr_wr    (csr_wr),
    .cmd_bits  (wr_data[3:0]),
    .ready     (ready_q),
    .drv_prot  (prot[da_drv]),
    .func_ld   (func_ld),
    .go_creset (go_creset),
    .go_wlock  (go_wlock),
    .go_refuse (go_refuse),
    .go_fwd    (go_fwd)
  );

  dskctl_protect #(.DRV_W(DRV_W)) i_protect (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (go_wlock),
    .set_drv (da_drv),
    .flags   (prot)
  );

  dskctl_attn i_attn (
    .clk   (clk),
    .rst_n (rst_n),
    .start (go_fwd),
    .ack   (attn_ack),
    .done  (srv_done),
    .attn  (attn_req)
  );

  always_comb begin
    func_n  = func_q;
    wle_n   = wle_q;
    ready_n = ready_q;
    da_n    = da_q;
    sfunc_n = srv_func;
    sdrv_n  = srv_drive;
    if (func_ld) func_n = wr_data[3:1];
    if (da_wr && ready_q) da_n = wr_data;
    if (go_creset) begin
      func_n = '0;
      wle_n  = 1'b0;
      da_n   = '0;
    end
    if (go_wlock)  wle_n = 1'b0;
    if (go_refuse) wle_n = 1'b1;
    if (go_fwd) begin
      wle_n   = 1'b0;
      ready_n = 1'b0;
      sfunc_n = wr_data[3:1];
      sdrv_n  = da_drv;
    end
    if (srv_done && !ready_q) ready_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q    <= '0;
      wle_q     <= 1'b0;
      ready_q   <= 1'b1;
      da_q      <= '0;
      srv_func  <= '0;
      srv_drive <= '0;
    end else begin
      func_q    <= func_n;
      wle_q     <= wle_n;
      ready_q   <= ready_n;
      da_q      <= da_n;
      srv_func  <= sfunc_n;
      srv_drive <= sdrv_n;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_CSR: begin
        rd_data[FUNC_W:1]    = func_q;
        rd_data[CSR_RDY_BIT] = ready_q;
        rd_data[CSR_WLE_BIT] = wle_q;
      end
      SEL_DA:  rd_data = da_q;
      SEL_STAT: begin
        rd_data[DATA_W-1 -: DRV_W] = da_drv;
        rd_data[STAT_WP_BIT]       = prot[da_drv];
      end
      default: rd_data = '0;
    endcase
  end

  assert_fwd_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(attn_req) |-> !ready_q);
  assert_busy_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_q && !srv_done |=> $stable(func_q) && $stable(da_q));
  assert_wlock_now_R7: assert property (@(posedge clk) disable iff (!rst_n)
    go_wlock |=> prot[$past(da_drv)] && ready_q);
  assert_refuse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    go_refuse && !attn_req |=> wle_q && !attn_req);
  assert_done_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    srv_done && !ready_q |=> ready_q);
endmodule

// File: tb/test_dskctl_regs.sv
module test_dskctl_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        attn_req;
  logic        attn_ack = 1'b0;
  logic        srv_done = 1'b0;
  logic [2:0]  srv_func;
  logic [2:0]  srv_drive;

  int n_checks = 0;
  int n_errors = 0;

  logic [1:0]  q_sel[$];
  logic [15:0] q_data[$];
  logic        q_attn[$];
  logic        q_srv[$];
  logic [5:0]  q_sval[$];
  string       q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dskctl_regs i_dskctl_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .attn_req(attn_req), .attn_ack(attn_ack),
    .srv_done(srv_done), .srv_func(srv_func), .srv_drive(srv_drive)
  );

  // driver side
  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0; attn_ack = 1'b0; srv_done = 1'b0;
  endtask

  task automatic pulse(input logic is_done);
    @(negedge clk);
    wr_en = 1'b0;
    if (is_done) srv_done = 1'b1; else attn_ack = 1'b1;
    idle();
  endtask

  task automatic expect_rd(input logic [1:0] sel, input logic [15:0] d, input logic a,
                           input string tag);
    @(negedge clk);
    q_sel.push_back(sel); q_data.push_back(d); q_attn.push_back(a);
    q_srv.push_back(1'b0); q_sval.push_back('0); q_tag.push_back(tag);
  endtask

  task automatic expect_srv(input logic [2:0] f, input logic [2:0] drv, input string tag);
    @(negedge clk);
    q_sel.push_back(2'd0); q_data.push_back('0); q_attn.push_back(1'b1);
    q_srv.push_back(1'b1); q_sval.push_back({f, drv}); q_tag.push_back(tag);
  endtask

  // monitor side
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (q_sel.size() > 0) begin
      logic [1:0]  s;
      logic [15:0] d;
      logic        a, chk_srv;
      logic [5:0]  sv;
      string       t;
      s = q_sel.pop_front(); d = q_data.pop_front(); a = q_attn.pop_front();
      chk_srv = q_srv.pop_front(); sv = q_sval.pop_front(); t = q_tag.pop_front();
      if (chk_srv) begin
        n_checks++;
        if ({srv_func, srv_drive} !== sv || attn_req !== a) begin
          n_errors++;
          $display("FAIL %s: srv=%o/%o attn=%b expected srv=%o/%o attn=%b",
                   t, srv_func, srv_drive, attn_req, sv[5:3], sv[2:0], a);
        end
      end else begin
        rd_sel = s;
        #1;
        n_checks++;
        if (rd_data !== d || attn_req !== a) begin
          n_errors++;
          $display("FAIL %s: sel=%0d data=%h attn=%b expected data=%h attn=%b",
                   t, s, rd_data, attn_req, d, a);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_rd(2'd0, 16'h0080, 1'b0, "R1 csr");
    expect_rd(2'd1, 16'h0000, 1'b0, "R1 da");
    expect_rd(2'd2, 16'h0000, 1'b0, "R1 status");
    expect_rd(2'd3, 16'h0000, 1'b0, "R11 unused sel");
    // R2 function stored without start
    wr(2'd0, 16'h0004); idle();
    expect_rd(2'd0, 16'h0084, 1'b0, "R2 no-go store");
    // R7 write-lock on drive 5
    wr(2'd1, 16'hA000); idle();
    expect_rd(2'd1, 16'hA000, 1'b0, "R11 da readback");
    expect_rd(2'd2, 16'hA000, 1'b0, "R11 status unprotected");
    wr(2'd0, 16'h000F); idle();
    expect_rd(2'd2, 16'hA020, 1'b0, "R7 drive5 protected");
    expect_rd(2'd0, 16'h008E, 1'b0, "R7 ready kept no attn");
    // R8 write-lock then control reset back to back on drive 2
    wr(2'd1, 16'h4000);
    wr(2'd0, 16'h000F);
    wr(2'd0, 16'h0001); idle();
    expect_rd(2'd0, 16'h0080, 1'b0, "R9 creset csr");
    expect_rd(2'd1, 16'h0000, 1'b0, "R9 creset da");
    wr(2'd1, 16'h4000); idle();
    expect_rd(2'd2, 16'h4020, 1'b0, "R8 lock survives creset");
    // R10 refused write and write-check on drive 5
    wr(2'd1, 16'hA000); idle();
    wr(2'd0, 16'h0003); idle();
    expect_rd(2'd0, 16'h2082, 1'b0, "R10 write refused");
    wr(2'd0, 16'h0007); idle();
    expect_rd(2'd0, 16'h2086, 1'b0, "R10 wchk refused");
    // R12/R3 forwarded read on drive 3 clears error
    wr(2'd1, 16'h6000); idle();
    wr(2'd0, 16'h0005); idle();
    expect_rd(2'd0, 16'h0004, 1'b1, "R12 R3 forwarded read");
    expect_srv(3'd2, 3'd3, "R3 server outputs");
    // R6 writes while busy ignored
    wr(2'd0, 16'h000F);
    wr(2'd1, 16'h0000); idle();
    expect_rd(2'd0, 16'h0004, 1'b1, "R6 csr frozen");
    expect_rd(2'd2, 16'h6000, 1'b1, "R6 da frozen, no lock");
    // R4 attention held then dropped by ack
    expect_rd(2'd0, 16'h0004, 1'b1, "R4 attn held");
    pulse(1'b0);
    expect_rd(2'd0, 16'h0004, 1'b0, "R4 attn dropped, still busy");
    // R5 done sets ready
    pulse(1'b1);
    expect_rd(2'd0, 16'h0084, 1'b0, "R5 ready after done");
    // R10 read to protected drive forwarded
    wr(2'd1, 16'hA000); idle();
    wr(2'd0, 16'h0005); idle();
    expect_rd(2'd0, 16'h0004, 1'b1, "R10 read forwarded");
    expect_srv(3'd2, 3'd5, "R10 read server drive");
    pulse(1'b1);
    expect_rd(2'd0, 16'h0084, 1'b0, "R5 R4 done drops attn");
    // R9 control reset keeps flags and clears error
    wr(2'd0, 16'h0003); idle();
    expect_rd(2'd0, 16'h2082, 1'b0, "R10 error set again");
    wr(2'd0, 16'h0001); idle();
    expect_rd(2'd0, 16'h0080, 1'b0, "R9 error cleared");
    wr(2'd1, 16'hA000); idle();
    expect_rd(2'd2, 16'hA020, 1'b0, "R9 flag kept");
    // R3 drive reset forwarded on drive 5
    wr(2'd0, 16'h000D); idle();
    expect_srv(3'd6, 3'd5, "R3 drive reset forwarded");
    expect_rd(2'd0, 16'h000C, 1'b1, "R3 busy after drive reset");
    pulse(1'b0);
    pulse(1'b1);
    expect_rd(2'd0, 16'h008C, 1'b0, "R5 done after drive reset");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule